// File: doc/BRIEF.md
# Recursive Handshake Modulo-N Counter

This block counts handshakes instead of holding a binary value. It is active on two four-phase channels. On the count channel it starts N complete request/acknowledge cycles. On the terminal channel it then starts exactly one cycle. After that the pattern begins again, with no limit on the number of repetitions. The environment only acknowledges, and it may take any number of clock cycles to do so. The block never waits on a particular latency.

Inside, the counter is a chain of header cells. There is one cell for each binary digit of N below the most significant one. A base cell takes the place of that top digit.

- An odd header first runs one count cycle of its own.
- An even header skips that leading cycle.
- After the optional leading cycle, each header waits for one of two requests from the cell beneath it. A pair request is served with two count cycles toward the parent. A terminal request is forwarded to the parent's terminal channel.
- The base cell simply alternates one count cycle and one terminal cycle.

The chain is therefore about log2(N) cells deep. N is fixed when the design is elaborated.

Top module: `hs_modn_counter`

## Requirements
- R1: While `rst_n` is low, `a_req` and `b_req` are both low. This holds whenever reset is applied, including in the middle of a frame.
- R2: The count channel is four-phase. Once raised, `a_req` stays high until `a_ack` is seen high. It is then dropped, and it is not raised again while `a_ack` is still high.
- R3: The terminal channel follows the same four-phase rule, using `b_req` and `b_ack`.
- R4: Between reset release (or the completion of the previous terminal handshake) and the completion of the next terminal handshake, exactly N count handshakes complete. A count handshake completes when `a_ack` returns low.
- R5: `a_req` and `b_req` are never high together. At the moment `b_req` rises, the count channel is fully idle: `a_req` and `a_ack` are both low.
- R6: The block needs no stimulus other than acknowledges. After each terminal handshake, the next count request follows without further input, for any acknowledge latency.
- R7: R4 holds for N = 1 (base cell only), for even N, for odd N, for N made of all ones, and for N a power of two.
- R8: After a reset in the middle of a frame, the count restarts from zero. The first terminal handshake after the reset is again preceded by exactly N count handshakes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset to the quiescent state |
| a_req | output | 1 | Count channel request |
| a_ack | input | 1 | Count channel acknowledge from the environment |
| b_req | output | 1 | Terminal channel request |
| b_ack | input | 1 | Terminal channel acknowledge from the environment |

## Verification
The return to zero of the last count handshake and the rise of the terminal request can fall in adjacent cycles. They can also fall in the same cycle of the chain, where a header leaves its pair service and its sub-cell raises its terminal request. Rows with zero acknowledge latency on both channels push the two events as close together as the design allows. At every rise of `b_req`, the bench checks that the count channel is fully idle and that exactly N count handshakes have completed. A reset applied while a handshake is open tests a second collision, reset against an active request. That case is judged by the outputs going low and by the next frame's length.

// File: rtl/hs_modn_pkg.sv
package hs_modn_pkg;

   // base cell: one count cycle, then one terminal cycle
   typedef enum logic [2:0] {
      BS_START,
      BS_A_UP,
      BS_A_DOWN,
      BS_B_UP,
      BS_B_DOWN
   } base_state_t;

   // header cell states
   typedef enum logic [3:0] {
      HS_START,
      HS_LEAD_UP,
      HS_LEAD_DOWN,
      HS_CHOOSE,
      HS_P1_UP,
      HS_P1_DOWN,
      HS_P2_UP,
      HS_P2_DOWN,
      HS_PAIR_ACK,
      HS_B_UP,
      HS_B_DOWN,
      HS_TERM_ACK
   } hdr_state_t;

   // number of header cells: binary digits of n below the top one
   function automatic int chain_depth(input int n);
      int d;
      d = 0;
      while ((n >> (d + 1)) != 0) d++;
      return d;
   endfunction

endpackage

// File: rtl/hs_modn_base.sv
module hs_modn_base
   import hs_modn_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   output logic up_a_req,
   input  logic up_a_ack,
   output logic up_b_req,
   input  logic up_b_ack
);

   base_state_t st, st_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) st <= BS_START;
      else        st <= st_nx;
   end

   always_comb begin
      st_nx = st;
      unique case (st)
         BS_START:  st_nx = BS_A_UP;
         BS_A_UP:   if (up_a_ack)  st_nx = BS_A_DOWN;
         BS_A_DOWN: if (!up_a_ack) st_nx = BS_B_UP;
         BS_B_UP:   if (up_b_ack)  st_nx = BS_B_DOWN;
         BS_B_DOWN: if (!up_b_ack) st_nx = BS_A_UP;
         default:   st_nx = BS_START;
      endcase
   end

   assign up_a_req = (st == BS_A_UP);
   assign up_b_req = (st == BS_B_UP);

   a_r2_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
      up_a_req && !up_a_ack |=> up_a_req);
   a_r3_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
      up_b_req && !up_b_ack |=> up_b_req);
   a_r3_base_rtz: assert property (@(posedge clk) disable iff (!rst_n)
      !up_b_req && up_b_ack |=> !up_b_req);

endmodule

// File: rtl/hs_modn_header.sv
module hs_modn_header
   import hs_modn_pkg::*;
#(
   parameter bit LOW_BIT = 1'b0
)(
   input  logic clk,
   input  logic rst_n,
   // toward the parent (active)
   output logic up_a_req,
   input  logic up_a_ack,
   output logic up_b_req,
   input  logic up_b_ack,
   // toward the sub-counter (passive)
   input  logic dn_a_req,
   output logic dn_a_ack,
   input  logic dn_b_req,
   output logic dn_b_ack
);

   hdr_state_t st, st_nx, loop_head;

   generate
      if (LOW_BIT) begin : g_odd
         assign loop_head = HS_LEAD_UP;
      end else begin : g_even
         assign loop_head = HS_CHOOSE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) st <= HS_START;
      else        st <= st_nx;
   end

   always_comb begin
      st_nx = st;
      unique case (st)
         HS_START:     st_nx = loop_head;
         HS_LEAD_UP:   if (up_a_ack)  st_nx = HS_LEAD_DOWN;
         HS_LEAD_DOWN: if (!up_a_ack) st_nx = HS_CHOOSE;
         HS_CHOOSE: begin
            if (dn_a_req)      st_nx = HS_P1_UP;
            else if (dn_b_req) st_nx = HS_B_UP;
         end
         HS_P1_UP:     if (up_a_ack)  st_nx = HS_P1_DOWN;
         HS_P1_DOWN:   if (!up_a_ack) st_nx = HS_P2_UP;
         HS_P2_UP:     if (up_a_ack)  st_nx = HS_P2_DOWN;
         HS_P2_DOWN:   if (!up_a_ack) st_nx = HS_PAIR_ACK;
         HS_PAIR_ACK:  if (!dn_a_req) st_nx = HS_CHOOSE;
         HS_B_UP:      if (up_b_ack)  st_nx = HS_B_DOWN;
         HS_B_DOWN:    if (!up_b_ack) st_nx = HS_TERM_ACK;
         HS_TERM_ACK:  if (!dn_b_req) st_nx = loop_head;
         default:      st_nx = HS_START;
      endcase
   end

   assign up_a_req = (st == HS_LEAD_UP) || (st == HS_P1_UP) || (st == HS_P2_UP);
   assign up_b_req = (st == HS_B_UP);
   assign dn_a_ack = (st == HS_PAIR_ACK);
   assign dn_b_ack = (st == HS_TERM_ACK);

   a_r2_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      up_a_req && !up_a_ack |=> up_a_req);
   a_r2_hdr_rtz: assert property (@(posedge clk) disable iff (!rst_n)
      !up_a_req && up_a_ack |=> !up_a_req);
   a_r3_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      up_b_req && !up_b_ack |=> up_b_req);
   // R5: the sub-counter offers only one alternative at a time
   a_r5_sub_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(dn_a_req && dn_b_req));
   a_r2_sub_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dn_a_ack && dn_a_req |=> dn_a_ack);

endmodule

// File: rtl/hs_modn_counter.sv
module hs_modn_counter
   import hs_modn_pkg::*;
#(
   parameter int MOD_N = 6
)(
   input  logic clk,
   input  logic rst_n,
   output logic a_req,
   input  logic a_ack,
   output logic b_req,
   input  logic b_ack
);

   localparam int DEPTH = chain_depth(MOD_N);
   localparam int CW    = $clog2(MOD_N + 2);

   generate
      if (MOD_N < 1) begin : g_bad_n
         $error("hs_modn_counter: MOD_N must be at least 1");
      end
   endgenerate

   // level 0 is the outer channel pair, level DEPTH is served by the base
   logic [DEPTH:0] lv_a_req, lv_a_ack, lv_b_req, lv_b_ack;

   assign lv_a_ack[0] = a_ack;
   assign lv_b_ack[0] = b_ack;
   assign a_req       = lv_a_req[0];
   assign b_req       = lv_b_req[0];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_hdr
         hs_modn_header #(
            .LOW_BIT(((MOD_N >> i) & 1) != 0)
         ) u_hdr (
            .clk      (clk),
            .rst_n    (rst_n),
            .up_a_req (lv_a_req[i]),
            .up_a_ack (lv_a_ack[i]),
            .up_b_req (lv_b_req[i]),
            .up_b_ack (lv_b_ack[i]),
            .dn_a_req (lv_a_req[i+1]),
            .dn_a_ack (lv_a_ack[i+1]),
            .dn_b_req (lv_b_req[i+1]),
            .dn_b_ack (lv_b_ack[i+1])
         );
      end
   endgenerate

   hs_modn_base u_base (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_a_req (lv_a_req[DEPTH]),
      .up_a_ack (lv_a_ack[DEPTH]),
      .up_b_req (lv_b_req[DEPTH]),
      .up_b_ack (lv_b_ack[DEPTH])
   );

   // checker state: completed count handshakes in the current frame
   logic          ack_q, bak_q;
   logic [CW-1:0] frame_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q     <= 1'b0;
         bak_q     <= 1'b0;
         frame_cnt <= '0;
      end else begin
         ack_q <= a_ack;
         bak_q <= b_ack;
         if (bak_q && !b_ack)               frame_cnt <= '0;
         else if (ack_q && !a_ack && !a_req) frame_cnt <= frame_cnt + 1'b1;
      end
   end

   a_r4_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(b_req) |-> (frame_cnt == CW'(MOD_N)));
   a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_req && b_req));
   a_r5_idle_at_b: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(b_req) |-> !a_ack);
   a_r1_quiet: assert property (@(posedge clk)
      !rst_n |=> !a_req && !b_req);

endmodule

// File: tb/hs_modn_counter_bench.sv
module hs_modn_counter_bench;

   localparam int NDUT = 6;
   localparam int NS [NDUT] = '{1, 2, 5, 6, 7, 8};
   localparam int NROW = 5;
   // lat_a, jit_a, lat_b, jit_b, frames
   localparam int ROWS [NROW][5] = '{
      '{0, 0, 0, 0, 3},
      '{1, 3, 0, 0, 3},
      '{0, 0, 5, 2, 3},
      '{7, 8, 3, 6, 2},
      '{2, 0, 2, 0, 3}
   };
   localparam int WD = 150000;

   logic clk = 1'b0;
   always #4 clk = ~clk;
   logic rst_n = 1'b0;

   logic a_req_w [NDUT];
   logic b_req_w [NDUT];
   logic a_ack_r [NDUT];
   logic b_ack_r [NDUT];

   generate
      for (genvar k = 0; k < NDUT; k++) begin : g_dut
         logic ar, br;
         hs_modn_counter #(.MOD_N(NS[k])) u_hs_modn_counter (
            .clk   (clk),
            .rst_n (rst_n),
            .a_req (ar),
            .a_ack (a_ack_r[k]),
            .b_req (br),
            .b_ack (b_ack_r[k])
         );
         assign a_req_w[k] = ar;
         assign b_req_w[k] = br;
      end
   endgenerate

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit wd_hit = 1'b0;
   int lat_a = 0, jit_a = 0, lat_b = 0, jit_b = 0;
   int a_cnt [NDUT], frames [NDUT], a_wait [NDUT], b_wait [NDUT], base [NDUT];
   bit a_prev [NDUT], b_prev [NDUT], fresh [NDUT];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int pick(input int lat, input int jit);
      return lat + ((jit > 0) ? int'($urandom_range(jit, 0)) : 0);
   endfunction

   task automatic clear_env();
      for (int k = 0; k < NDUT; k++) begin
         a_ack_r[k] = 1'b0; b_ack_r[k] = 1'b0;
         a_cnt[k] = 0; a_wait[k] = 0; b_wait[k] = 0;
         a_prev[k] = 1'b0; b_prev[k] = 1'b0;
      end
   endtask

   // one negedge of environment: acknowledge and judge every counter
   task automatic step();
      @(negedge clk);
      cyc++;
      if (cyc > WD) wd_hit = 1'b1;
      if (rst_n) begin
         for (int k = 0; k < NDUT; k++) begin
            if (a_prev[k] && !a_ack_r[k] && !a_req_w[k])
               chk(1'b0, $sformatf("R2 a_req dropped early N=%0d", NS[k]), 0, 1);
            if (b_prev[k] && !b_ack_r[k] && !b_req_w[k])
               chk(1'b0, $sformatf("R3 b_req dropped early N=%0d", NS[k]), 0, 1);
            if (b_req_w[k] && !b_prev[k])
               chk(!a_req_w[k] && !a_ack_r[k] && !b_ack_r[k],
                   $sformatf("R5 count channel idle at b_req rise N=%0d", NS[k]),
                   {29'd0, a_req_w[k], a_ack_r[k], b_ack_r[k]}, 0);
            if (a_req_w[k] != a_ack_r[k]) begin
               if (a_wait[k] > 0) a_wait[k]--;
               else begin
                  a_ack_r[k] = a_req_w[k];
                  a_wait[k]  = pick(lat_a, jit_a);
                  if (!a_req_w[k]) a_cnt[k]++;
               end
            end
            if (b_req_w[k] != b_ack_r[k]) begin
               if (b_wait[k] > 0) b_wait[k]--;
               else begin
                  b_ack_r[k] = b_req_w[k];
                  b_wait[k]  = pick(lat_b, jit_b);
                  if (!b_req_w[k]) begin
                     if (fresh[k])
                        chk(a_cnt[k] == NS[k],
                            $sformatf("R8 first frame after reset N=%0d", NS[k]),
                            a_cnt[k], NS[k]);
                     else
                        chk(a_cnt[k] == NS[k],
                            $sformatf("R4 frame length R7 N=%0d", NS[k]),
                            a_cnt[k], NS[k]);
                     fresh[k] = 1'b0;
                     a_cnt[k] = 0;
                     frames[k]++;
                  end
               end
            end
            a_prev[k] = a_req_w[k];
            b_prev[k] = b_req_w[k];
         end
      end
   endtask

   initial begin
      bit done;
      for (int k = 0; k < NDUT; k++) begin
         frames[k] = 0; fresh[k] = 1'b0; base[k] = 0;
      end
      clear_env();
      rst_n = 1'b0;
      repeat (5) step();
      for (int k = 0; k < NDUT; k++)
         chk(!a_req_w[k] && !b_req_w[k], $sformatf("R1 quiet in reset N=%0d", NS[k]),
             {30'd0, a_req_w[k], b_req_w[k]}, 0);
      rst_n = 1'b1;

      for (int r = 0; r < NROW && !wd_hit; r++) begin
         lat_a = ROWS[r][0]; jit_a = ROWS[r][1];
         lat_b = ROWS[r][2]; jit_b = ROWS[r][3];
         for (int k = 0; k < NDUT; k++) base[k] = frames[k];
         done = 1'b0;
         while (!done && !wd_hit) begin
            step();
            done = 1'b1;
            for (int k = 0; k < NDUT; k++)
               if (frames[k] - base[k] < ROWS[r][4]) done = 1'b0;
         end
         for (int k = 0; k < NDUT; k++)
            chk(frames[k] - base[k] >= ROWS[r][4],
                $sformatf("R6 frames repeat row %0d N=%0d", r, NS[k]),
                frames[k] - base[k], ROWS[r][4]);

         if (r == 2) begin
            // reset in the middle of a frame
            repeat (37) step();
            rst_n = 1'b0;
            clear_env();
            repeat (3) step();
            for (int k = 0; k < NDUT; k++) begin
               chk(!a_req_w[k] && !b_req_w[k],
                   $sformatf("R1 quiet after mid-frame reset N=%0d", NS[k]),
                   {30'd0, a_req_w[k], b_req_w[k]}, 0);
               fresh[k] = 1'b1;
            end
            rst_n = 1'b1;
         end
      end

      if (wd_hit) chk(1'b0, "watchdog expired", cyc, WD);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule